// File: doc/BRIEF.md
# Stack Pointer and Call/Return Sequencer

This block keeps the 8-bit stack pointer of a small microcontroller core. It also performs every stack access the core needs. The stack grows upward through internal RAM. The pointer always names the most recently written byte, and it comes out of reset at 07h.

A single-byte push first advances the pointer and then stores the byte. A single-byte pop first reads the byte and then steps the pointer back. A subroutine call saves a 16-bit program counter in two successive stores, low byte first. A return or interrupt return reads the two bytes back, high byte first. An interrupt return also sends a one-cycle pulse that tells the interrupt logic to clear its in-service flag.

A write port lets the core load the pointer directly. A small internal RAM model holds the stack bytes. Its address, write data and write strobe are brought out so the core can watch them.

Commands arrive on a valid/ready channel. A command transfers on a rising edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, the source must hold `cmd_valid`, `cmd_op`, `push_data` and `call_pc` steady. `cmd_ready` drops during the second step of a call or return, and in any cycle where the pointer is being written. The results (`done`, `pop_data`, `pc_restored`, `irq_clr`) are plain status pins with no back-pressure.

Top module: `spu_stack_unit`

## Requirements
- R1: After reset the pointer reads 07h, `cmd_ready` is 1, and `done`, `ram_we` and `irq_clr` are 0.
- R2: A push (op 1) transferred in cycle T does three things in T: it drives `ram_we`=1, drives `ram_addr` to the pointer plus 1, and drives `ram_wdata` to `push_data`. In T+1 the pointer holds the new address and `done` is 1 for that one cycle.
- R3: A pop (op 2) transferred in cycle T reads the byte at the pointer. In T+1, `pop_data` holds that byte, the pointer is one lower, and `done` is 1.
- R4: A call (op 3) transferred in cycle T writes `call_pc[7:0]` at pointer+1 in T. In T+1 it writes `call_pc[15:8]` at the next address, with `cmd_ready` low. In T+2 the pointer has advanced by two and `done` is 1.
- R5: A return (op 4) transferred in cycle T reads the high PC byte at the pointer in T and the low byte one address lower in T+1. In T+2, `pc_restored` holds the full PC, the pointer has dropped by two, `done` is 1 and `irq_clr` is 0.
- R6: An interrupt return (op 5) behaves like a return. In addition, `irq_clr` is 1 in exactly the cycle where its `done` is 1.
- R7: Pointer arithmetic wraps modulo 256. A push at FFh stores at 00h, and a pop at 00h leaves FFh. No address, including the register-bank area, is protected.
- R8: A pointer write is visible on `sp_value` in the next cycle. During the write cycle, `cmd_ready` and `ram_we` are 0. A write during the second step of a call or return abandons that step: there is no second RAM access and no `done`.
- R9: A command held while `cmd_ready` is low transfers once, on the first cycle where `cmd_ready` is high. Op codes 0, 6 and 7 transfer but write nothing, leave the pointer unchanged and raise no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can transfer this cycle |
| cmd_op | input | 3 | 1 push, 2 pop, 3 call, 4 return, 5 interrupt return |
| push_data | input | 8 | Byte to push |
| call_pc | input | 16 | Program counter saved by a call |
| sp_wr_en | input | 1 | Load the pointer |
| sp_wr_data | input | 8 | Value loaded into the pointer |
| sp_value | output | 8 | Current pointer |
| ram_addr | output | 8 | Stack RAM address this cycle |
| ram_wdata | output | 8 | Stack RAM write data |
| ram_we | output | 1 | Stack RAM write strobe |
| pop_data | output | 8 | Byte returned by the last pop |
| pc_restored | output | 16 | PC rebuilt by the last return |
| done | output | 1 | One-cycle completion pulse |
| irq_clr | output | 1 | In-service clear pulse from an interrupt return |

## Verification
The bench covers four corner cases.

- **Byte order of a call and return.** It checks the byte order of a saved and restored PC at the exact addresses. A swapped order would return a PC with its bytes exchanged.
- **Pointer wrap.** It pushes at FFh and pops at 00h. A design without modular wrap would store past the array or leave a 9-bit value.
- **Pointer write mid-sequence.** It writes the pointer halfway through a call, then reads the untouched byte back through a pop. A design that still finished the call would overwrite that byte and pulse `done`.
- **Collision and unknown ops.** It holds a push against a pointer write, and it sends an unknown op. A design that dropped the held command, or acted on the unknown op, shows the wrong pointer or a false `done`.

// File: rtl/spu_pkg.sv
`timescale 1ns/1ps
package spu_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_RETI = 3'd5
  } spu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CALL_HI = 2'd1,
    ST_RET_LO  = 2'd2
  } spu_state_e;
endpackage

// File: rtl/spu_sp_reg.sv
`timescale 1ns/1ps
module spu_sp_reg #(
  parameter int          AW       = 8,
  parameter logic [AW-1:0] SP_RESET = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          inc,
  input  logic          dec,
  output logic [AW-1:0] sp
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] sp_d;

  always_comb begin
    if (wr_en)    sp_d = wr_data;
    else if (inc) sp_d = sp + ONE;
    else if (dec) sp_d = sp - ONE;
    else          sp_d = sp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sp <= SP_RESET;
    else        sp <= sp_d;
  end

  // R8: a direct load wins over any step
  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> sp == $past(wr_data));

  // R7: increment from all-ones wraps to zero
  p_wrap_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inc) && !$past(wr_en) && $past(sp) == {AW{1'b1}}) |-> sp == '0);

  // R7: decrement from zero wraps to all-ones
  p_wrap_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dec) && !$past(wr_en) && $past(sp) == '0) |-> sp == {AW{1'b1}});
endmodule

// File: rtl/spu_ram.sv
`timescale 1ns/1ps
module spu_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

  // R2: a strobed write is stored at the strobed address
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we) |-> mem[$past(addr)] == $past(wdata));
endmodule

// File: rtl/spu_seq.sv
`timescale 1ns/1ps
module spu_seq
  import spu_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [DW-1:0]   push_data,
  input  logic [2*DW-1:0] call_pc,
  input  logic            sp_wr_en,
  input  logic [AW-1:0]   sp,
  input  logic [DW-1:0]   rdata,
  output logic            ram_we,
  output logic [AW-1:0]   ram_addr,
  output logic [DW-1:0]   ram_wdata,
  output logic            sp_inc,
  output logic            sp_dec,
  output logic [DW-1:0]   pop_data,
  output logic [2*DW-1:0] pc_out,
  output logic            done,
  output logic            irq_clr
);
  localparam int            PCW = 2 * DW;
  localparam logic [AW-1:0] ONE = AW'(1);

  spu_state_e    state_q, state_d;
  spu_op_e       op;
  logic [DW-1:0] pc_hi_q;
  logic          reti_q;
  logic          accept;
  logic          done_d;
  logic          irq_d;

  assign op        = spu_op_e'(cmd_op);
  assign cmd_ready = (state_q == ST_IDLE) && !sp_wr_en;
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    state_d   = state_q;
    ram_we    = 1'b0;
    ram_addr  = sp;
    ram_wdata = '0;
    sp_inc    = 1'b0;
    sp_dec    = 1'b0;
    done_d    = 1'b0;
    irq_d     = 1'b0;
    if (sp_wr_en) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            case (op)
              OP_PUSH: begin
                ram_we    = 1'b1;
                ram_addr  = sp + ONE;
                ram_wdata = push_data;
                sp_inc    = 1'b1;
                done_d    = 1'b1;
              end
              OP_POP: begin
                sp_dec = 1'b1;
                done_d = 1'b1;
              end
              OP_CALL: begin
                ram_we    = 1'b1;
                ram_addr  = sp + ONE;
                ram_wdata = call_pc[DW-1:0];
                sp_inc    = 1'b1;
                state_d   = ST_CALL_HI;
              end
              OP_RET, OP_RETI: begin
                sp_dec  = 1'b1;
                state_d = ST_RET_LO;
              end
              default: ;
            endcase
          end
        end
        ST_CALL_HI: begin
          ram_we    = 1'b1;
          ram_addr  = sp + ONE;
          ram_wdata = pc_hi_q;
          sp_inc    = 1'b1;
          done_d    = 1'b1;
          state_d   = ST_IDLE;
        end
        ST_RET_LO: begin
          sp_dec  = 1'b1;
          done_d  = 1'b1;
          irq_d   = reti_q;
          state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pc_hi_q  <= '0;
      reti_q   <= 1'b0;
      pop_data <= '0;
      pc_out   <= '0;
      done     <= 1'b0;
      irq_clr  <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
      irq_clr <= irq_d;
      if (accept && op == OP_CALL) pc_hi_q <= call_pc[PCW-1:DW];
      if (accept) reti_q <= (op == OP_RETI);
      if (accept && op == OP_POP) pop_data <= rdata;
      if (accept && (op == OP_RET || op == OP_RETI)) pc_out[PCW-1:DW] <= rdata;
      if (state_q == ST_RET_LO && !sp_wr_en) pc_out[DW-1:0] <= rdata;
    end
  end

  // R4: the cycle after a call is taken stores the high PC byte, unless a load aborts it
  p_call_hi_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_CALL) |=>
      (sp_wr_en || (ram_we && ram_wdata == $past(call_pc[PCW-1:DW]))));

  // R5: the second read of a return is followed by a completion pulse
  p_ret_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RET_LO && !sp_wr_en) |=> done);

  // R6: the in-service clear never appears without completion
  p_irq_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |-> done);

  // R8: a pointer load blocks transfers and RAM writes
  p_load_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr_en |-> (!ram_we && !cmd_ready));
endmodule

// File: rtl/spu_stack_unit.sv
`timescale 1ns/1ps
module spu_stack_unit #(
  parameter int          AW       = 8,
  parameter int          DW       = 8,
  parameter logic [7:0]  SP_RESET = 8'h07
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [2:0]  cmd_op,
  input  logic [7:0]  push_data,
  input  logic [15:0] call_pc,
  input  logic        sp_wr_en,
  input  logic [7:0]  sp_wr_data,
  output logic [7:0]  sp_value,
  output logic [7:0]  ram_addr,
  output logic [7:0]  ram_wdata,
  output logic        ram_we,
  output logic [7:0]  pop_data,
  output logic [15:0] pc_restored,
  output logic        done,
  output logic        irq_clr
);
  logic          sp_inc, sp_dec;
  logic [DW-1:0] rdata;

  spu_sp_reg #(.AW(AW), .SP_RESET(SP_RESET)) u_sp (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sp_wr_en),
    .wr_data (sp_wr_data),
    .inc     (sp_inc),
    .dec     (sp_dec),
    .sp      (sp_value)
  );

  spu_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .push_data (push_data),
    .call_pc   (call_pc),
    .sp_wr_en  (sp_wr_en),
    .sp        (sp_value),
    .rdata     (rdata),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .sp_inc    (sp_inc),
    .sp_dec    (sp_dec),
    .pop_data  (pop_data),
    .pc_out    (pc_restored),
    .done      (done),
    .irq_clr   (irq_clr)
  );

  spu_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (rdata)
  );

  // R1: right after reset the pointer holds its reset value
  p_reset_sp_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> sp_value == SP_RESET);
endmodule

// File: tb/spu_stack_unit_bench.sv
`timescale 1ns/1ps
module spu_stack_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [7:0]  push_data = 8'h00;
  logic [15:0] call_pc = 16'h0000;
  logic        sp_wr_en = 1'b0;
  logic [7:0]  sp_wr_data = 8'h00;
  logic [7:0]  sp_value, ram_addr, ram_wdata, pop_data;
  logic        ram_we, done, irq_clr;
  logic [15:0] pc_restored;

  int checks = 0;
  int failures = 0;
  logic       t_we;
  logic [7:0] t_addr, t_wdata;

  always #5 clk = ~clk;

  spu_stack_unit u_spu_stack_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .push_data(push_data), .call_pc(call_pc),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .sp_value(sp_value),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .pop_data(pop_data), .pc_restored(pc_restored), .done(done),
    .irq_clr(irq_clr)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] d, input logic [15:0] pc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; push_data = d; call_pc = pc;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    t_we = ram_we; t_addr = ram_addr; t_wdata = ram_wdata;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    #1;
  endtask

  task automatic set_sp(input logic [7:0] v);
    @(negedge clk);
    sp_wr_en = 1'b1; sp_wr_data = v;
    @(negedge clk);
    sp_wr_en = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    check("R1", "sp after reset", sp_value, 8'h07);
    check("R1", "ready after reset", cmd_ready, 1'b1);
    check("R1", "done after reset", done, 1'b0);
    check("R1", "we after reset", ram_we, 1'b0);
    check("R1", "irq_clr after reset", irq_clr, 1'b0);
  endtask

  task automatic t_push_pop;
    set_sp(8'h58);
    check("R8", "sp load", sp_value, 8'h58);
    issue(3'd1, 8'h2B, 16'h0);
    check("R2", "push we", t_we, 1'b1);
    check("R2", "push addr", t_addr, 8'h59);
    check("R2", "push data", t_wdata, 8'h2B);
    check("R2", "push done", done, 1'b1);
    check("R2", "push sp", sp_value, 8'h59);
    @(negedge clk); #1;
    check("R2", "done single pulse", done, 1'b0);
    issue(3'd2, 8'h0, 16'h0);
    check("R3", "pop data", pop_data, 8'h2B);
    check("R3", "pop sp", sp_value, 8'h58);
    check("R3", "pop done", done, 1'b1);
  endtask

  task automatic t_call_ret;
    issue(3'd3, 8'h0, 16'h1234);
    check("R4", "call low addr", t_addr, 8'h59);
    check("R4", "call low data", t_wdata, 8'h34);
    check("R4", "call high we", ram_we, 1'b1);
    check("R4", "call high addr", ram_addr, 8'h5A);
    check("R4", "call high data", ram_wdata, 8'h12);
    check("R4", "ready low in step two", cmd_ready, 1'b0);
    check("R4", "no early done", done, 1'b0);
    @(negedge clk); #1;
    check("R4", "call done", done, 1'b1);
    check("R4", "call sp", sp_value, 8'h5A);
    issue(3'd4, 8'h0, 16'h0);
    check("R5", "ret step two addr", ram_addr, 8'h59);
    check("R5", "no early done", done, 1'b0);
    @(negedge clk); #1;
    check("R5", "ret done", done, 1'b1);
    check("R5", "ret pc", pc_restored, 16'h1234);
    check("R5", "ret sp", sp_value, 8'h58);
    check("R6", "plain ret no irq_clr", irq_clr, 1'b0);
  endtask

  task automatic t_reti;
    issue(3'd3, 8'h0, 16'hABCD);
    @(negedge clk); #1;
    issue(3'd5, 8'h0, 16'h0);
    check("R6", "irq_clr not early", irq_clr, 1'b0);
    @(negedge clk); #1;
    check("R6", "reti done", done, 1'b1);
    check("R6", "reti irq_clr", irq_clr, 1'b1);
    check("R6", "reti pc", pc_restored, 16'hABCD);
    @(negedge clk); #1;
    check("R6", "irq_clr single pulse", irq_clr, 1'b0);
  endtask

  task automatic t_wrap;
    set_sp(8'hFF);
    issue(3'd1, 8'h77, 16'h0);
    check("R7", "wrap push addr", t_addr, 8'h00);
    check("R7", "wrap push sp", sp_value, 8'h00);
    issue(3'd2, 8'h0, 16'h0);
    check("R7", "wrap pop data", pop_data, 8'h77);
    check("R7", "wrap pop sp", sp_value, 8'hFF);
  endtask

  task automatic t_collision;
    @(negedge clk);
    sp_wr_en = 1'b1; sp_wr_data = 8'h40;
    cmd_valid = 1'b1; cmd_op = 3'd1; push_data = 8'h99;
    #1;
    check("R8", "ready during load", cmd_ready, 1'b0);
    check("R8", "we during load", ram_we, 1'b0);
    @(negedge clk);
    sp_wr_en = 1'b0;
    #1;
    check("R8", "sp loaded", sp_value, 8'h40);
    check("R9", "held push now ready", cmd_ready, 1'b1);
    check("R9", "held push addr", ram_addr, 8'h41);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    #1;
    check("R9", "held push sp", sp_value, 8'h41);
    @(negedge clk); #1;
    check("R9", "held push transferred once", sp_value, 8'h41);
    issue(3'd2, 8'h0, 16'h0);
    check("R9", "held push byte", pop_data, 8'h99);
  endtask

  task automatic t_abort;
    set_sp(8'h21);
    issue(3'd1, 8'hEE, 16'h0);
    set_sp(8'h20);
    issue(3'd3, 8'h0, 16'h5566);
    sp_wr_en = 1'b1; sp_wr_data = 8'h30;
    #1;
    check("R8", "aborted step no write", ram_we, 1'b0);
    @(negedge clk);
    sp_wr_en = 1'b0;
    #1;
    check("R8", "aborted call no done", done, 1'b0);
    check("R8", "aborted call sp", sp_value, 8'h30);
    check("R8", "ready after abort", cmd_ready, 1'b1);
    set_sp(8'h22);
    issue(3'd2, 8'h0, 16'h0);
    check("R8", "high byte not written", pop_data, 8'hEE);
    set_sp(8'h21);
    issue(3'd2, 8'h0, 16'h0);
    check("R4", "first step landed", pop_data, 8'h66);
  endtask

  task automatic t_unknown;
    set_sp(8'h33);
    issue(3'd6, 8'h55, 16'h0);
    check("R9", "unknown op no write", t_we, 1'b0);
    check("R9", "unknown op no done", done, 1'b0);
    check("R9", "unknown op sp", sp_value, 8'h33);
    issue(3'd0, 8'h55, 16'h0);
    check("R9", "nop no done", done, 1'b0);
    check("R9", "nop sp", sp_value, 8'h33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_push_pop();
    t_call_ret();
    t_reti();
    t_wrap();
    t_collision();
    t_abort();
    t_unknown();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule